// File: doc/BRIEF.md
# Multiword DMA Host Engine for a Parallel ATA Device Port

This block is the host side of an IDE multiword DMA data phase. When a transfer is armed, it waits for the device to raise its DMA request. It then acknowledges with an active-low acknowledge. It then issues a train of active-low read or write strobes, and each strobe moves one 16-bit word. Write words come from a valid/ready source stream, normally the read side of a FIFO. Read words leave as single-cycle valid pulses into a sink, which signals free space with a ready line.

The transfer length, the direction and one of three timing modes are latched on a start pulse. Every strobe is gated at its start by the device request and by FIFO readiness, so a stalled FIFO or a dropped request only lengthens the gap between words. The strobe itself is never shortened. After the last word the acknowledge is held for a mode-dependent time, and then it is released with a one-cycle done pulse. An abort that is seen while the engine waits between words ends the transfer through the same release path.

All timing is counted in cycles of the block clock. Each cycle count is the nanosecond figure divided by the clock period and rounded up.

Top module: `mwdma_host`

## Requirements
- R1: After reset, the acknowledge and both strobes are high, and `done`, `busy`, `rd_valid` and `dd_oe` are low.
- R2: The acknowledge falls only on the clock edge after the engine, armed and waiting, has sampled the device request high. No strobe is active unless the acknowledge is low.
- R3: The mode encoding is 0, 1 or 2, and code 3 behaves as mode 2. Each strobe stays low for exactly ceil(240 ns/T) cycles in mode 0 and ceil(80 ns/T) cycles in modes 1 and 2. T is the clock period, giving 30, 10 and 10 cycles at 8 ns. Only one strobe line is low at a time.
- R4: When requests and FIFOs never stall, the spacing from one strobe fall to the next is exactly ceil(480/T), ceil(160/T) or ceil(120/T) cycles in modes 0, 1 and 2. This is 60, 20 and 15 cycles at 8 ns.
- R5: On a write (`xfer_write`=1), a word is taken from the source on the edge where the write strobe falls. `dd_out` carries that word with `dd_oe` high from that edge until the acknowledge is released.
- R6: On a read (`xfer_write`=0), the bus word present at the edge where the read strobe rises is presented on `rd_data`, with `rd_valid` high for the following cycle. Words are delivered in strobe order.
- R7: No strobe begins on an edge where the device request was sampled low. The acknowledge stays low through such a pause, and it falls once per transfer.
- R8: No write strobe begins unless `wr_valid` was high, and no read strobe begins unless `rd_ready` was high, at that edge.
- R9: A transfer of N words issues exactly N strobes. The acknowledge rises exactly ceil(20/T), ceil(15/T) or ceil(10/T) cycles after the last strobe rises, in modes 0, 1 and 2 (3, 2 and 2 cycles at 8 ns). `done` is high for one cycle on that same edge.
- R10: An abort sampled while waiting for the request before acknowledge ends the transfer with `done` and no acknowledge. An abort sampled between words releases the acknowledge after at least the hold time and raises `done`, and no further strobe is issued.
- R11: A start with a word count of zero raises `done` on the next edge, without acknowledge or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a transfer and latches its settings |
| xfer_write | input | 1 | 1 = host to device, 0 = device to host |
| mode | input | 2 | Timing mode 0..2 (3 acts as 2) |
| word_count | input | CNT_W | Words to move |
| abort | input | 1 | Ends a waiting transfer |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | Host DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | DATA_W | Write word driven to the device bus |
| dd_oe | output | 1 | Drive enable for dd_out |
| dd_in | input | DATA_W | Word from the device bus |
| wr_data | input | DATA_W | Source word for writes |
| wr_valid | input | 1 | Source word available |
| wr_ready | output | 1 | Engine takes the source word this edge |
| rd_data | output | DATA_W | Word read from the device |
| rd_valid | output | 1 | rd_data valid for one cycle |
| rd_ready | input | 1 | Sink has room for one word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench sweeps all four mode codes, both directions and one- and three-word transfers. It runs each one free-running, with the request toggling, and with the FIFO side stalling. Every strobe width, every unstalled word spacing and the release delay after the last word are measured against counts computed from the nanosecond figures. An off-by-one in the timer reloads would show up as a strobe or spacing one cycle long or short, and a wrong hold counter would release the acknowledge early. The stall runs catch a design that starts a strobe on a dropped request or an empty or full FIFO, or that releases the acknowledge during a pause. The abort, zero-count and end-of-transfer runs catch a missing done pulse, a stray extra strobe and an acknowledge that never comes back.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_GAP,
    S_STRB,
    S_RECOV,
    S_HOLD
  } mw_state_t;

  function automatic int cdiv(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // minimum strobe low time per mode
  function automatic int act_ns(input int m);
    return (m == 0) ? 240 : 80;
  endfunction

  // minimum word cycle per mode
  function automatic int cyc_ns(input int m);
    case (m)
      0:       return 480;
      1:       return 160;
      default: return 120;
    endcase
  endfunction

  // release time after last strobe: larger of acknowledge hold and write data hold
  function automatic int hold_ns(input int m);
    case (m)
      0:       return 20;
      1:       return 15;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/mwdma_timing.sv
module mwdma_timing
  import mwdma_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int TMR_W  = 8
) (
  input  logic [1:0]       mode,
  output logic [TMR_W-1:0] act_cyc,
  output logic [TMR_W-1:0] rec_cyc,
  output logic [TMR_W-1:0] hold_cyc
);

  localparam int NMODES = 4;

  logic [TMR_W-1:0] act_t  [NMODES];
  logic [TMR_W-1:0] rec_t  [NMODES];
  logic [TMR_W-1:0] hold_t [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int A0 = cdiv(act_ns(m), CLK_NS);
    localparam int A  = (A0 < 1) ? 1 : A0;
    localparam int C  = cdiv(cyc_ns(m), CLK_NS);
    localparam int R  = (C - A < 2) ? 2 : C - A;
    localparam int H0 = cdiv(hold_ns(m), CLK_NS);
    localparam int H  = (H0 < 1) ? 1 : H0;
    assign act_t[m]  = TMR_W'(A);
    assign rec_t[m]  = TMR_W'(R);
    assign hold_t[m] = TMR_W'(H);
  end

  assign act_cyc  = act_t[mode];
  assign rec_cyc  = rec_t[mode];
  assign hold_cyc = hold_t[mode];

endmodule

// File: rtl/mwdma_wcount.sv
module mwdma_wcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == CNT_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0)); // R9

endmodule

// File: rtl/mwdma_host.sv
module mwdma_host
  import mwdma_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              xfer_write,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              abort,
  input  logic              dmarq,
  output logic              dmack_n,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  input  logic [DATA_W-1:0] dd_in,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              done
);

  mw_state_t        state;
  logic [TMR_W-1:0] tmr;
  logic [1:0]       mode_q;
  logic             wr_q;
  logic [TMR_W-1:0] act_cyc, rec_cyc, hold_cyc;
  logic             last_word;
  logic             cnt_load, cnt_dec, tmr_zero, go;

  mwdma_timing #(.CLK_NS(CLK_NS), .TMR_W(TMR_W)) u_timing (
    .mode     (mode_q),
    .act_cyc  (act_cyc),
    .rec_cyc  (rec_cyc),
    .hold_cyc (hold_cyc)
  );

  assign cnt_load = (state == S_IDLE) && start;
  assign tmr_zero = (tmr == '0);
  assign cnt_dec  = (state == S_STRB) && tmr_zero;

  mwdma_wcount #(.CNT_W(CNT_W)) u_wcount (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (word_count),
    .dec      (cnt_dec),
    .last     (last_word)
  );

  // a word may start only with request up, FIFO side ready and no abort
  assign go       = (state == S_GAP) && dmarq && !abort && (wr_q ? wr_valid : rd_ready);
  assign wr_ready = (state == S_GAP) && wr_q && dmarq && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      tmr      <= '0;
      dmack_n  <= 1'b1;
      dior_n   <= 1'b1;
      diow_n   <= 1'b1;
      dd_out   <= '0;
      dd_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      busy     <= 1'b0;
      mode_q   <= '0;
      wr_q     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (word_count == '0) begin
              done <= 1'b1;
            end else begin
              state  <= S_REQ;
              busy   <= 1'b1;
              mode_q <= mode;
              wr_q   <= xfer_write;
            end
          end
        end
        S_REQ: begin
          if (abort) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else if (dmarq) begin
            dmack_n <= 1'b0;
            state   <= S_GAP;
          end
        end
        S_GAP: begin
          if (abort) begin
            state <= S_HOLD;
            tmr   <= hold_cyc - TMR_W'(1);
          end else if (go) begin
            state <= S_STRB;
            tmr   <= act_cyc - TMR_W'(1);
            if (wr_q) begin
              diow_n <= 1'b0;
              dd_out <= wr_data;
              dd_oe  <= 1'b1;
            end else begin
              dior_n <= 1'b0;
            end
          end
        end
        S_STRB: begin
          if (tmr_zero) begin
            dior_n <= 1'b1;
            diow_n <= 1'b1;
            if (!wr_q) begin
              rd_data  <= dd_in;
              rd_valid <= 1'b1;
            end
            if (last_word) begin
              state <= S_HOLD;
              tmr   <= hold_cyc - TMR_W'(1);
            end else begin
              state <= S_RECOV;
              tmr   <= rec_cyc - TMR_W'(2);
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        S_RECOV: begin
          if (tmr_zero) state <= S_GAP;
          else          tmr   <= tmr - TMR_W'(1);
        end
        S_HOLD: begin
          if (tmr_zero) begin
            dmack_n <= 1'b1;
            dd_oe   <= 1'b0;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic             strb_act;
  logic [TMR_W-1:0] chk_low;

  assign strb_act = !dior_n || !diow_n;

  always_ff @(posedge clk) begin
    if (rst)           chk_low <= '0;
    else if (strb_act) chk_low <= chk_low + TMR_W'(1);
    else               chk_low <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n)); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_act) |-> (chk_low == act_cyc)); // R3
  AST_ACK_COVERS_STROBE: assert property (@(posedge clk) disable iff (rst)
    strb_act |-> !dmack_n); // R2
  AST_REQ_GATES_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_act) |-> $past(dmarq)); // R7
  AST_SRC_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(diow_n) |-> $past(wr_valid)); // R8
  AST_SINK_GATES_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(dior_n) |-> $past(rd_ready)); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> dmack_n); // R9

endmodule

// File: tb/mwdma_host_test.sv
`timescale 1ns/1ps
module mwdma_host_test;

  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        xfer_write = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] word_count = '0;
  logic        abort = 1'b0;
  logic        dmarq = 1'b0;
  logic        dmack_n, dior_n, diow_n, dd_oe, wr_ready, rd_valid, busy, done;
  logic [15:0] dd_out, dd_in, wr_data, rd_data;
  logic        wr_valid = 1'b0;
  logic        rd_ready = 1'b0;

  always #4 clk = ~clk;

  mwdma_host uut (
    .clk(clk), .rst(rst), .start(start), .xfer_write(xfer_write), .mode(mode),
    .word_count(word_count), .abort(abort), .dmarq(dmarq), .dmack_n(dmack_n),
    .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cdiv(input int ns);
    return (ns + T - 1) / T;
  endfunction

  function automatic logic [15:0] src_word(input int i);
    return 16'(16'h5A00 + i * 16'h0123);
  endfunction
  function automatic logic [15:0] dev_word(input int i);
    return 16'(16'hC3A5 ^ (i * 16'h0F1D));
  endfunction

  // transfer configuration and trackers
  int cfg_kind = 0, cyc = 0;
  bit cfg_abort = 0, xfer_on = 0;
  int exp_a = 0, exp_c = 0, exp_h = 0;
  int wr_idx = 0, rd_idx = 0, strobe_cnt = 0, ack_falls = 0;
  int low_cnt = 0, since_fall = 0, since_rise = 0;
  bit have_prev = 0, done_seen = 0;
  bit strb_q = 0, dmack_q = 1, done_q = 0;
  logic dmarq_e = 0, wrv_e = 0, rdr_e = 0;

  assign wr_data = src_word(wr_idx);
  assign dd_in   = dev_word(rd_idx);

  always @(posedge clk) begin
    dmarq_e <= dmarq;
    wrv_e   <= wr_valid;
    rdr_e   <= rd_ready;
  end

  // stimulus for the device request, FIFO side and abort
  always @(negedge clk) begin
    if (xfer_on) begin
      bit ok;
      cyc++;
      case (cfg_kind)
        1:       dmarq = (cyc >= 4) && ((cyc % 23) < 15);
        3:       dmarq = (cyc >= 4) && (cyc < 30);
        4:       dmarq = 1'b0;
        default: dmarq = (cyc >= 4);
      endcase
      ok       = (cfg_kind == 2) ? ((cyc % 17) < 9) : 1'b1;
      wr_valid = ok;
      rd_ready = ok;
      abort    = (cfg_kind == 3 && cyc == 45) || (cfg_kind == 4 && cyc == 10);
    end else begin
      dmarq = 0; wr_valid = 0; rd_ready = 0; abort = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      bit strb, fell, rose;
      strb = !dior_n || !diow_n;
      fell = strb && !strb_q;
      rose = !strb && strb_q;
      if (strb) chk(!dmack_n, "R2 strobe without ack", dmack_n, 0);
      if (fell) begin
        strobe_cnt++;
        chk(dmarq_e, "R7 strobe started on low request", dmarq_e, 1);
        chk(xfer_write ? wrv_e : rdr_e, "R8 strobe started on fifo stall", 0, 1);
        chk(xfer_write ? (!diow_n && dior_n) : (!dior_n && diow_n), "R3 strobe line", dior_n, diow_n);
        if (cfg_kind == 0 && have_prev)
          chk(since_fall == exp_c, "R4 word spacing", since_fall, exp_c);
        have_prev  = 1;
        since_fall = 1;
        if (xfer_write) begin
          chk(dd_out == src_word(wr_idx) && dd_oe, "R5 write word", dd_out, src_word(wr_idx));
          wr_idx++;
        end
      end else begin
        since_fall++;
      end
      if (strb) low_cnt++;
      else if (rose) begin
        chk(low_cnt == exp_a, "R3 strobe width", low_cnt, exp_a);
        low_cnt = 0;
      end
      if (xfer_write && !dmack_n && have_prev)
        chk(dd_oe && dd_out == src_word(wr_idx - 1), "R5 write data held", dd_out, src_word(wr_idx - 1));
      if (rd_valid) begin
        chk(!xfer_write && rd_data == dev_word(rd_idx), "R6 read word", rd_data, dev_word(rd_idx));
        rd_idx++;
      end
      if (!dmack_n && dmack_q) begin
        ack_falls++;
        chk(dmarq_e, "R2 ack without request", dmarq_e, 1);
        chk(strobe_cnt == 0, "R2 strobe before ack", strobe_cnt, 0);
      end
      if (dmack_n && !dmack_q) begin
        if (!cfg_abort) chk(since_rise == exp_h, "R9 ack hold", since_rise, exp_h);
        else            chk(since_rise >= exp_h, "R10 ack hold on abort", since_rise, exp_h);
      end
      since_rise = strb ? 0 : since_rise + 1;
      if (done) begin
        done_seen = 1;
        chk(dmack_n, "R9 done with ack low", dmack_n, 1);
        chk(!done_q, "R9 done longer than one cycle", 2, 1);
      end
      strb_q  = strb;
      dmack_q = dmack_n;
      done_q  = done;
    end
  end

  task automatic run(input int m, input bit wr, input int n, input int kind,
                     input int exp_n, input int exp_ack, input string req);
    int mm;
    @(negedge clk);
    mm = (m == 3) ? 2 : m;
    exp_a = cdiv(mm == 0 ? 240 : 80);
    exp_c = cdiv(mm == 0 ? 480 : (mm == 1 ? 160 : 120));
    exp_h = cdiv(mm == 0 ? 20 : (mm == 1 ? 15 : 10));
    cfg_kind = kind; cfg_abort = (kind >= 3);
    wr_idx = 0; rd_idx = 0; strobe_cnt = 0; ack_falls = 0;
    have_prev = 0; done_seen = 0; low_cnt = 0;
    mode = 2'(m); xfer_write = wr; word_count = 16'(n);
    cyc = 0; xfer_on = 1; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 6000 && !done_seen; i++) @(negedge clk);
    xfer_on = 0;
    chk(done_seen, {req, " done"}, done_seen, 1);
    chk(strobe_cnt == exp_n, {req, " strobe count"}, strobe_cnt, exp_n);
    chk((wr ? wr_idx : rd_idx) == exp_n, {req, " words moved"}, wr ? wr_idx : rd_idx, exp_n);
    chk(ack_falls == exp_ack, {req, " ack count (R7)"}, ack_falls, exp_ack);
    @(negedge clk);
    chk(dmack_n && !busy && !dd_oe, {req, " idle after end"}, busy, 0);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dmack_n && dior_n && diow_n && !done && !busy && !rd_valid && !dd_oe,
        "R1 reset state", {dmack_n, dior_n, diow_n}, 7);
    @(negedge clk);
    rst = 0;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++) begin
          run(m, w[0], 1, k, 1, 1, "R9 single");
          run(m, w[0], 3, k, 3, 1, "R9 multi");
        end
    run(2, 1'b1, 5, 3, 2, 1, "R10 abort between words");
    run(2, 1'b0, 5, 3, 2, 1, "R10 abort between reads");
    run(1, 1'b1, 3, 4, 0, 0, "R10 abort before ack");
    run(0, 1'b1, 0, 0, 0, 0, "R11 zero count");
    run(2, 1'b0, 0, 0, 0, 0, "R11 zero count read");
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule